// File: doc/BRIEF.md
# Watchdog Timer with Vector-Overlaid Service Location

This block is a computer-operating-properly watchdog for a small 8-bit microcontroller. A prescaler divides the oscillator clock into ticks, and a timeout counter counts those ticks. If software does not service the watchdog before the selected limit is reached, the block raises a system reset request. The request stays up for a fixed number of cycles. After it drops, counting starts again from zero.

Software services the watchdog by writing to one fixed bus address. That address is shared with the low byte of the reset vector. A write strobe to it clears both the counter and the prescaler, whatever data the CPU puts on the bus. A read of the same address returns the vector byte from memory and does not touch the counter.

Two configuration bits control the watchdog. One turns it off and the other picks between a long and a short timeout. Monitor-mode entry can also turn it off. Entry with the test voltage disables the watchdog only while that voltage is present. Entry caused by blank vectors disables it until the next power-on reset. Stop status freezes the count, while wait status has no effect on it.

Top module: `cop_watchdog`

## Requirements
- R1: While `cfg_disable_i` is 1, `cop_rst_req_o` stays 0 and the counter and prescaler are held at zero. Once it returns to 0, a full timeout elapses before a request.
- R2: The timeout is TO_LONG*PRE_DIV clock cycles when `cfg_rate_i`=0 and TO_SHORT*PRE_DIV cycles when `cfg_rate_i`=1. It is measured from the service edge to the edge that raises `cop_rst_req_o`.
- R3: A clock edge with `bus_wr_i`=1 and `bus_addr_i`=SVC_ADDR clears the counter and prescaler, so a new full timeout starts. A write to any other address has no effect on the timing.
- R4: While `bus_rd_i`=1 and `bus_addr_i`=SVC_ADDR, `bus_rdata_o` equals `vec_lo_i` in the same cycle, and it is 0 otherwise. Reads never change the timeout.
- R5: `cop_rst_req_o` stays high for exactly HOLD cycles. The next timeout then falls a full period after the request drops.
- R6: A `mon_entry_i` pulse with `mon_tst_irq_i`=1 disables the watchdog while `mon_tst_irq_i` or `mon_tst_rst_i` is 1. Once both are 0, the watchdog times out normally again.
- R7: A `mon_entry_i` pulse with `mon_tst_irq_i`=0 and `mon_blank_vec_i`=1 disables the watchdog. This survives `rst_ni` pulses and is cleared only by `por_ni`.
- R8: `wait_i` has no effect on the timeout.
- R9: While `stop_i`=1, the counter is frozen and the prescaler is cleared. Suppose `stop_i` is high for s edges, beginning m edges after a service. The timeout then becomes the nominal timeout + s + (m mod PRE_DIV).
- R10: During reset, `cop_rst_req_o`=0. After `rst_ni` releases, the first timeout falls a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low power-on reset; clears the sticky monitor disable |
| cfg_disable_i | input | 1 | Configuration watchdog disable |
| cfg_rate_i | input | 1 | Timeout select: 0 long, 1 short |
| mon_entry_i | input | 1 | One-cycle pulse on monitor-mode entry |
| mon_tst_irq_i | input | 1 | Test voltage present on the interrupt pin |
| mon_tst_rst_i | input | 1 | Test voltage present on the reset pin |
| mon_blank_vec_i | input | 1 | Reset vectors are blank |
| wait_i | input | 1 | Wait-mode status |
| stop_i | input | 1 | Stop-mode status; gates the prescaled clock |
| bus_addr_i | input | ADDR_W | CPU address |
| bus_wr_i | input | 1 | CPU write strobe |
| bus_rd_i | input | 1 | CPU read strobe |
| vec_lo_i | input | DATA_W | Reset-vector low byte from memory |
| bus_rdata_o | output | DATA_W | Read data for the service address |
| cop_rst_req_o | output | 1 | System reset request |

## Verification
The reset request is a registered output. It rises at the clock edge that lies exactly limit*PRE_DIV edges after the service edge, so the bench counts sample points from the sample just after the service edge and expects that exact count. With stop, the expected count grows by the stop length plus the prescaler phase that stop discards. The request is counted for exactly HOLD samples, and the following period is measured from the sample where it falls. Read data is combinational, so it is sampled a moment after the read strobe is driven in the same cycle. All inputs change at falling edges and all outputs are sampled there.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef enum logic {
    RATE_LONG  = 1'b0,
    RATE_SHORT = 1'b1
  } rate_e;

  typedef enum logic [1:0] {
    LP_RUN    = 2'b00,
    LP_WAIT   = 2'b01,
    LP_STOP   = 2'b10,
    LP_STOP_W = 2'b11
  } lp_mode_e;

  // prescaled clock is present in run and wait, absent in stop
  function automatic logic lp_clk_on(lp_mode_e m);
    unique case (m)
      LP_RUN, LP_WAIT:    return 1'b1;
      LP_STOP, LP_STOP_W: return 1'b0;
      default:            return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cop_bus_decode.sv
module cop_bus_decode #(
  parameter int unsigned    ADDR_W   = 16,
  parameter int unsigned    DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] vec_lo_i,
  output logic              svc_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit;
  assign hit     = (addr_i == SVC_ADDR);
  assign svc_o   = wr_i & hit;
  // location is shared with vector memory: reads see the vector byte
  assign rdata_o = (rd_i & hit) ? vec_lo_i : '0;
endmodule

// File: rtl/cop_mon_ctrl.sv
module cop_mon_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic entry_i,
  input  logic tst_irq_i,
  input  logic tst_rst_i,
  input  logic blank_i,
  output logic mon_dis_o
);
  logic hv_q, sticky_q;

  // high-voltage entry: released once test voltage leaves both pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hv_q <= 1'b0;
    else if (entry_i && tst_irq_i)  hv_q <= 1'b1;
    else if (!tst_irq_i && !tst_rst_i) hv_q <= 1'b0;
  end

  // blank-vector entry: only power-on clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                                  sticky_q <= 1'b0;
    else if (entry_i && !tst_irq_i && blank_i)    sticky_q <= 1'b1;
  end

  assign mon_dis_o = hv_q | sticky_q;
endmodule

// File: rtl/cop_prescaler.sv
module cop_prescaler #(
  parameter int unsigned PRE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  if (PRE_DIV <= 1) begin : g_bypass
    assign tick_o = en_i & ~clr_i;
  end else begin : g_div
    localparam int unsigned PRE_W = $clog2(PRE_DIV);
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRE_DIV - 1);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pre_q <= '0;
      else if (clr_i)  pre_q <= '0;
      else if (en_i)   pre_q <= (pre_q == PRE_MAX) ? '0 : pre_q + 1'b1;
    end

    assign tick_o = en_i & ~clr_i & (pre_q == PRE_MAX);
  end
endmodule

// File: rtl/cop_timeout_ctr.sv
module cop_timeout_ctr
  import cop_pkg::*;
#(
  parameter int unsigned TO_LONG  = 262128,
  parameter int unsigned TO_SHORT = 8176,
  parameter int unsigned HOLD     = 32
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  clr_i,
  input  logic  kill_i,
  input  rate_e rate_i,
  output logic  req_o
);
  localparam int unsigned LIM_MAX = (TO_LONG > TO_SHORT) ? TO_LONG : TO_SHORT;
  localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);
  localparam int unsigned HOLD_W  = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0]  LIM_L = CNT_W'(TO_LONG - 1);
  localparam logic [CNT_W-1:0]  LIM_S = CNT_W'(TO_SHORT - 1);
  localparam logic [HOLD_W-1:0] HOLD_LD = HOLD_W'(HOLD - 1);

  logic [CNT_W-1:0]  cnt_q, lim_m1;
  logic [HOLD_W-1:0] hold_q;
  logic              req_q;

  assign lim_m1 = (rate_i == RATE_SHORT) ? LIM_S : LIM_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
      req_q  <= 1'b0;
    end else if (kill_i) begin
      cnt_q  <= '0;
      hold_q <= '0;
      req_q  <= 1'b0;
    end else if (req_q) begin
      // request window: counter parked at zero, service ignored
      cnt_q <= '0;
      if (hold_q == '0) req_q  <= 1'b0;
      else              hold_q <= hold_q - 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q >= lim_m1) begin
        cnt_q  <= '0;
        req_q  <= 1'b1;
        hold_q <= HOLD_LD;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 16'hFFFF,
  parameter int unsigned       PRE_DIV  = 4,
  parameter int unsigned       TO_LONG  = 262128,
  parameter int unsigned       TO_SHORT = 8176,
  parameter int unsigned       HOLD     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              cfg_disable_i,
  input  logic              cfg_rate_i,
  input  logic              mon_entry_i,
  input  logic              mon_tst_irq_i,
  input  logic              mon_tst_rst_i,
  input  logic              mon_blank_vec_i,
  input  logic              wait_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] vec_lo_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              cop_rst_req_o
);
  logic     svc, mon_dis, kill, clk_on, pre_clr, tick, req;
  lp_mode_e lp_mode;

  assign lp_mode = lp_mode_e'({stop_i, wait_i});
  assign clk_on  = lp_clk_on(lp_mode);

  cop_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR)
  ) u_dec (
    .addr_i(bus_addr_i), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .vec_lo_i(vec_lo_i), .svc_o(svc), .rdata_o(bus_rdata_o)
  );

  cop_mon_ctrl u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni),
    .entry_i(mon_entry_i), .tst_irq_i(mon_tst_irq_i),
    .tst_rst_i(mon_tst_rst_i), .blank_i(mon_blank_vec_i),
    .mon_dis_o(mon_dis)
  );

  assign kill    = cfg_disable_i | mon_dis;
  assign pre_clr = svc | kill | req | ~clk_on;

  cop_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(clk_on),
    .clr_i(pre_clr), .tick_o(tick)
  );

  cop_timeout_ctr #(
    .TO_LONG(TO_LONG), .TO_SHORT(TO_SHORT), .HOLD(HOLD)
  ) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .clr_i(svc),
    .kill_i(kill), .rate_i(rate_e'(cfg_rate_i)), .req_o(req)
  );

  assign cop_rst_req_o = req;
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 16'hFFFF,
  parameter int unsigned       HOLD     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              cfg_disable_i,
  input logic              mon_entry_i,
  input logic              mon_tst_irq_i,
  input logic              mon_blank_vec_i,
  input logic              stop_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [DATA_W-1:0] vec_lo_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              cop_rst_req_o
);
  localparam int unsigned HC_W = $clog2(HOLD + 2);
  logic [HC_W-1:0] hi_cnt;
  logic            sticky_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hi_cnt <= '0;
    else if (cop_rst_req_o) hi_cnt <= hi_cnt + 1'b1;
    else                    hi_cnt <= '0;
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) sticky_seen <= 1'b0;
    else if (mon_entry_i && !mon_tst_irq_i && mon_blank_vec_i) sticky_seen <= 1'b1;
  end

  a_r1_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_disable_i |=> !cop_rst_req_o);

  a_r3_service_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == SVC_ADDR && !cop_rst_req_o) |=> !cop_rst_req_o);

  a_r5_hold_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_rst_req_o |-> (hi_cnt < HC_W'(HOLD)));

  a_r7_sticky_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_seen |=> !cop_rst_req_o);

  a_r9_stop_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !cop_rst_req_o) |=> !cop_rst_req_o);

  always_comb begin
    if (bus_rd_i && bus_addr_i == SVC_ADDR)
      a_r4_rdata_vec: assert (bus_rdata_o == vec_lo_i);
  end
endmodule

bind cop_watchdog cop_watchdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR), .HOLD(HOLD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni),
  .cfg_disable_i(cfg_disable_i), .mon_entry_i(mon_entry_i),
  .mon_tst_irq_i(mon_tst_irq_i), .mon_blank_vec_i(mon_blank_vec_i),
  .stop_i(stop_i), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i), .vec_lo_i(vec_lo_i), .bus_rdata_o(bus_rdata_o),
  .cop_rst_req_o(cop_rst_req_o)
);

// File: tb/cop_watchdog_bench.sv
`timescale 1ns/1ps
module cop_watchdog_bench;
  localparam int unsigned PRE    = 4;
  localparam int unsigned TL     = 60;
  localparam int unsigned TS     = 12;
  localparam int unsigned HOLD_N = 32;
  localparam logic [15:0] SVC    = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n, por_n, cfg_dis, rate, mon_entry, tst_irq, tst_rst, blank;
  logic wait_s, stop_s, wr, rd;
  logic [15:0] addr;
  logic [7:0]  vec, rdata;
  logic        req;

  int vec_cnt = 0;
  int fail_cnt = 0;
  int n_cyc;
  int early;

  always #10 clk = ~clk;

  cop_watchdog #(
    .PRE_DIV(PRE), .TO_LONG(TL), .TO_SHORT(TS), .HOLD(HOLD_N)
  ) u_cop_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .cfg_disable_i(cfg_dis),
    .cfg_rate_i(rate), .mon_entry_i(mon_entry), .mon_tst_irq_i(tst_irq),
    .mon_tst_rst_i(tst_rst), .mon_blank_vec_i(blank), .wait_i(wait_s),
    .stop_i(stop_s), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .vec_lo_i(vec), .bus_rdata_o(rdata), .cop_rst_req_o(req)
  );

  function automatic int t0(logic r);
    return (r ? TS : TL) * PRE;
  endfunction

  function automatic int exp_stop(logic r, int m, int s);
    return t0(r) + s + (m % PRE);
  endfunction

  task automatic chk(string rq, int act, int exp);
    vec_cnt++;
    if (act != exp) begin
      fail_cnt++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    n_cyc++;
    if (req) early = 1;
  endtask

  task automatic do_reset(bit por);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
  endtask

  task automatic service();
    wr = 1'b1; addr = SVC;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic run_until_req(int maxc);
    while (!req && n_cyc < maxc) begin
      @(negedge clk);
      n_cyc++;
    end
  endtask

  task automatic hold_len(output int c);
    c = 0;
    while (req && c < 1000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic quiet(int cycles, output int seen);
    seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (req) seen = 1;
    end
  endtask

  task automatic rnd_step();
    logic [7:0] v;
    int r;
    r = $urandom % 8;
    wait_s = 1'($urandom % 2);
    if (r == 0) begin
      rd = 1'b1; addr = SVC; v = 8'($urandom); vec = v;
      #1;
      chk("R4 rdata", int'(rdata), int'(v));
    end else if (r == 1) begin
      wr = 1'b1; addr = 16'($urandom);
      if (addr == SVC) addr = 16'h0000;
    end
    step();
    rd = 1'b0; wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end

  initial begin
    int h, seen, m, s, kind;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; por_n = 1'b0; cfg_dis = 1'b0; rate = 1'b0;
    mon_entry = 1'b0; tst_irq = 1'b0; tst_rst = 1'b0; blank = 1'b0;
    wait_s = 1'b0; stop_s = 1'b0; wr = 1'b0; rd = 1'b0;
    addr = '0; vec = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R10 req in reset", int'(req), 0);
    chk("R4 rdata idle", int'(rdata), 0);
    rst_n = 1'b1; por_n = 1'b1;

    // R10: first timeout a full period after release; R5: hold and restart
    n_cyc = 0; run_until_req(5000);
    chk("R10 first timeout", n_cyc, t0(0));
    hold_len(h);
    chk("R5 hold length", h, HOLD_N);
    n_cyc = 0; run_until_req(5000);
    chk("R5 restart period", n_cyc, t0(0));
    hold_len(h);

    // R2: short rate
    rate = 1'b1;
    service(); n_cyc = 0; run_until_req(5000);
    chk("R2 short timeout", n_cyc, t0(1));
    hold_len(h);
    chk("R5 hold length", h, HOLD_N);

    // R1: disable
    cfg_dis = 1'b1;
    service();
    quiet(3 * t0(0), seen);
    chk("R1 disabled quiet", seen, 0);
    cfg_dis = 1'b0;
    n_cyc = 0; run_until_req(5000);
    chk("R1 full period after enable", n_cyc, t0(1));
    hold_len(h);

    // R4: read of service address leaves timing alone; other address reads 0
    service(); n_cyc = 0;
    repeat (3) step();
    rd = 1'b1; addr = SVC; vec = 8'hC3; #1;
    chk("R4 rdata vector", int'(rdata), 8'hC3);
    step();
    addr = 16'h1234; #1;
    chk("R4 rdata other", int'(rdata), 0);
    step(); rd = 1'b0;
    run_until_req(5000);
    chk("R4 read no effect", n_cyc, t0(1));
    hold_len(h);

    // R3: write elsewhere ignored, service mid-period restarts
    rate = 1'b0;
    service(); n_cyc = 0; early = 0;
    repeat (t0(0) - 10) step();
    wr = 1'b1; addr = 16'hFFFE; step(); wr = 1'b0;
    chk("R3 no early request", early, 0);
    run_until_req(5000);
    chk("R3 other address ignored", n_cyc, t0(0));
    hold_len(h);
    service(); n_cyc = 0; early = 0;
    repeat (t0(0) - 5) step();
    service(); n_cyc = 0;
    chk("R3 no request before reservice", early, 0);
    run_until_req(5000);
    chk("R3 reservice full period", n_cyc, t0(0));
    hold_len(h);

    // R8: wait mode keeps counting
    wait_s = 1'b1;
    service(); n_cyc = 0; run_until_req(5000);
    chk("R8 wait timeout", n_cyc, t0(0));
    hold_len(h);
    wait_s = 1'b0;

    // R9: stop freezes count and drops prescaler phase
    service(); n_cyc = 0;
    repeat (7) step();
    stop_s = 1'b1; repeat (20) step(); stop_s = 1'b0;
    run_until_req(5000);
    chk("R9 stop extends", n_cyc, exp_stop(0, 7, 20));
    hold_len(h);

    // R6: high-voltage monitor entry
    do_reset(1'b0);
    tst_irq = 1'b1; mon_entry = 1'b1; @(negedge clk); mon_entry = 1'b0;
    quiet(3 * t0(0), seen);
    chk("R6 disabled irq voltage", seen, 0);
    tst_irq = 1'b0; tst_rst = 1'b1;
    quiet(3 * t0(0), seen);
    chk("R6 disabled reset voltage", seen, 0);
    tst_rst = 1'b0;
    repeat (2) @(negedge clk);
    service(); n_cyc = 0; run_until_req(5000);
    chk("R6 resumes after voltage", n_cyc, t0(0));
    hold_len(h);

    // R7: blank-vector monitor entry is sticky until power-on
    do_reset(1'b0);
    blank = 1'b1; mon_entry = 1'b1; @(negedge clk); mon_entry = 1'b0; blank = 1'b0;
    quiet(3 * t0(0), seen);
    chk("R7 disabled after entry", seen, 0);
    do_reset(1'b0);
    quiet(3 * t0(0), seen);
    chk("R7 survives system reset", seen, 0);
    do_reset(1'b1);
    n_cyc = 0; run_until_req(5000);
    chk("R7 power-on clears", n_cyc, t0(0));
    hold_len(h);

    // random mix
    for (int it = 0; it < 30; it++) begin
      @(negedge clk);
      rate = 1'($urandom % 2);
      kind = $urandom % 3;
      m = $urandom % (t0(rate) - PRE);
      s = 1 + $urandom % 25;
      service(); n_cyc = 0; early = 0;
      repeat (m) rnd_step();
      if (kind == 1) begin
        stop_s = 1'b1;
        repeat (s) step();
        stop_s = 1'b0;
      end else if (kind == 2) begin
        service(); n_cyc = 0;
      end
      chk("R3 no early request (random)", early, 0);
      run_until_req(10000);
      if (kind == 1) chk("R9 random stop", n_cyc, exp_stop(rate, m, s));
      else           chk("R2 random timeout", n_cyc, t0(rate));
      hold_len(h);
      chk("R5 random hold", h, HOLD_N);
      wait_s = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end
endmodule